// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Controller

This block keeps the rows of a 1024-row DRAM refreshed. A falling row strobe with the refresh strobe held low runs one internal refresh on the row that an on-chip counter points to. The counter then steps to the next row. A falling row strobe under one particular combination of the other strobes puts the controller into self-refresh. In that mode a timer issues refresh cycles by itself from the same counter. The mode lasts until the row strobe rises again.

Leaving self-refresh starts a recovery window of fixed length. Any row-strobe fall inside that window is flagged as a protocol error and dropped. The controller also keeps a power-down flag that follows chip select. A deadline monitor warns when a window of configured length held fewer refreshes than required.

All strobes are sampled on the rising clock edge. Every result appears on registered outputs at the edge that samples the cause. The block has no data stream, so every pin is a plain control or status line with no handshake.

Top module: `refresh_ctrl`

## Requirements
- R1: When an edge first samples `row_n` low after a high sample, with `rfsh_n` low and the controller idle, `refresh_pulse` is 1 for exactly that one clock and `refresh_row` shows the counter value.
- R2: The row counter moves forward by one after each refresh, whether internal or self-timed. It wraps from ROWS-1 (1023 by default) to 0 and starts at 0 after reset.
- R3: A row-strobe fall in the idle state enters self-refresh when it is sampled with `sel_n`, `wr_sel`, `rfsh_n` and `we_n` all high and `col_n` low. `self_active` is then 1 from that edge onward.
- R4: In self-refresh, a refresh pulse is issued SELF_PERIOD clocks after entry and then every SELF_PERIOD clocks. The default period is chosen so that 1024 refreshes fit in 64 ms at 250 MHz.
- R5: The first edge that samples `row_n` high in self-refresh ends the mode. No refresh is issued on that edge.
- R6: `recovery_busy` is 1 for exactly RECOVER_CYC clocks after self-refresh ends. It is never 1 while `self_active` is 1.
- R7: A row-strobe fall sampled during recovery raises `proto_err` for one clock. It issues no refresh, does not step the counter and does not enter self-refresh.
- R8: `low_power` follows `sel_n` with one clock of delay. A value of 1 means standby.
- R9: At the end of each WINDOW_CYC-clock window (counted from reset), `budget_warn` is set if fewer than REQ_REFRESH refresh pulses occurred in that window. Otherwise it is cleared. It is 0 after reset.
- R10: An idle row-strobe fall that matches neither the refresh nor the self-refresh condition issues no refresh and leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Chip select, active low; high requests standby |
| wr_sel | input | 1 | Write/read selector strobe |
| rfsh_n | input | 1 | Refresh strobe, active low |
| row_n | input | 1 | Row strobe, active low |
| col_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| refresh_pulse | output | 1 | One-clock marker of an issued refresh |
| refresh_row | output | ROW_BITS | Row refreshed by the current pulse |
| self_active | output | 1 | Self-refresh mode; also the I/O power-gate flag |
| recovery_busy | output | 1 | Post-self-refresh recovery window |
| proto_err | output | 1 | One-clock flag for an access during recovery |
| low_power | output | 1 | Standby flag |
| budget_warn | output | 1 | Refresh deadline warning |

## Verification
Refresh pulses, mode changes, protocol errors and the standby flag all appear at the edge that samples the strobe. The bench therefore drives each strobe on a falling edge and reads the result at the next falling edge. Self-refresh pulses come SELF_PERIOD edges after entry. For a stay of D clocks the bench expects (D-1)/SELF_PERIOD pulses, and it expects exactly RECOVER_CYC busy samples after exit. The budget warning is read well after a window boundary, never on it, so the exact phase of the boundary does not matter.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SELF    = 2'd1,
    ST_RECOVER = 2'd2
  } rf_state_t;

  typedef struct packed {
    logic fall;      // row strobe fell at this edge
    logic rfsh_req;  // refresh strobe low on the fall
    logic self_req;  // self-refresh combination on the fall
    logic row_high;  // row strobe currently high
  } strobe_ev_t;
endpackage

// File: rtl/strobe_decode.sv
module strobe_decode
  import refresh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_n,
  input  logic       wr_sel,
  input  logic       rfsh_n,
  input  logic       row_n,
  input  logic       col_n,
  input  logic       we_n,
  output strobe_ev_t ev
);
  logic row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= 1'b1;
    else        row_q <= row_n;
  end

  always_comb begin
    ev.fall     = row_q & ~row_n;
    ev.rfsh_req = ~rfsh_n;
    ev.self_req = sel_n & wr_sel & rfsh_n & we_n & ~col_n;
    ev.row_high = row_n;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/row_counter.sv
module row_counter #(
  parameter int ROW_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  output logic [ROW_BITS-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row <= '0;
    else if (step) row <= row + 1'b1;
  end
endmodule

// File: rtl/budget_monitor.sv
module budget_monitor #(
  parameter int WINDOW_CYC  = 16_000_000,
  parameter int REQ_REFRESH = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic warn
);
  localparam int WIN_W = (WINDOW_CYC > 1) ? $clog2(WINDOW_CYC) : 1;
  localparam int TAL_W = $clog2(REQ_REFRESH + 1);

  logic [WIN_W-1:0] win_cnt;
  logic [TAL_W-1:0] tally, tally_nx;
  logic             win_end;

  assign win_end  = (win_cnt == WIN_W'(WINDOW_CYC - 1));
  assign tally_nx = (tick && tally != TAL_W'(REQ_REFRESH)) ? tally + 1'b1 : tally;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      tally   <= '0;
      warn    <= 1'b0;
    end else if (win_end) begin
      win_cnt <= '0;
      tally   <= '0;
      warn    <= (tally_nx < TAL_W'(REQ_REFRESH));
    end else begin
      win_cnt <= win_cnt + 1'b1;
      tally   <= tally_nx;
    end
  end
endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int ROW_BITS    = 10,
  parameter int SELF_PERIOD = 15_625,
  parameter int RECOVER_CYC = 32,
  parameter int WINDOW_CYC  = 16_000_000,
  parameter int REQ_REFRESH = 1 << ROW_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_n,
  input  logic                wr_sel,
  input  logic                rfsh_n,
  input  logic                row_n,
  input  logic                col_n,
  input  logic                we_n,
  output logic                refresh_pulse,
  output logic [ROW_BITS-1:0] refresh_row,
  output logic                self_active,
  output logic                recovery_busy,
  output logic                proto_err,
  output logic                low_power,
  output logic                budget_warn
);
  localparam int SELF_W = $clog2(SELF_PERIOD + 1);
  localparam int REC_W  = $clog2(RECOVER_CYC + 1);

  strobe_ev_t          ev;
  rf_state_t           state, state_nx;
  logic                do_ref, err_nx;
  logic                self_load, self_zero, rec_load, rec_zero;
  logic [ROW_BITS-1:0] row_now;

  strobe_decode u_dec (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_sel(wr_sel),
    .rfsh_n(rfsh_n), .row_n(row_n), .col_n(col_n), .we_n(we_n), .ev(ev)
  );

  tick_timer #(.W(SELF_W)) u_self_tmr (
    .clk(clk), .rst_n(rst_n), .load(self_load),
    .load_val(SELF_W'(SELF_PERIOD - 1)), .zero(self_zero)
  );

  tick_timer #(.W(REC_W)) u_rec_tmr (
    .clk(clk), .rst_n(rst_n), .load(rec_load),
    .load_val(REC_W'(RECOVER_CYC - 1)), .zero(rec_zero)
  );

  row_counter #(.ROW_BITS(ROW_BITS)) u_rows (
    .clk(clk), .rst_n(rst_n), .step(do_ref), .row(row_now)
  );

  budget_monitor #(.WINDOW_CYC(WINDOW_CYC), .REQ_REFRESH(REQ_REFRESH)) u_budget (
    .clk(clk), .rst_n(rst_n), .tick(refresh_pulse), .warn(budget_warn)
  );

  always_comb begin
    state_nx  = state;
    do_ref    = 1'b0;
    err_nx    = 1'b0;
    self_load = 1'b0;
    rec_load  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (ev.fall && ev.rfsh_req) begin
          do_ref = 1'b1;
        end else if (ev.fall && ev.self_req) begin
          state_nx  = ST_SELF;
          self_load = 1'b1;
        end
      end
      ST_SELF: begin
        if (ev.row_high) begin
          state_nx = ST_RECOVER;
          rec_load = 1'b1;
        end else if (self_zero) begin
          do_ref    = 1'b1;
          self_load = 1'b1;
        end
      end
      ST_RECOVER: begin
        err_nx = ev.fall;
        if (rec_zero) state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      refresh_pulse <= 1'b0;
      refresh_row   <= '0;
      proto_err     <= 1'b0;
      low_power     <= 1'b0;
    end else begin
      state         <= state_nx;
      refresh_pulse <= do_ref;
      proto_err     <= err_nx;
      low_power     <= sel_n;
      if (do_ref) refresh_row <= row_now;
    end
  end

  assign self_active   = (state == ST_SELF);
  assign recovery_busy = (state == ST_RECOVER);
endmodule

// File: rtl/refresh_ctrl_chk.sv
module refresh_ctrl_chk #(
  parameter int ROW_BITS = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sel_n,
  input logic                rfsh_n,
  input logic                row_n,
  input logic                refresh_pulse,
  input logic [ROW_BITS-1:0] refresh_row,
  input logic                self_active,
  input logic                recovery_busy,
  input logic                proto_err,
  input logic                low_power
);
  logic                row_prev, armed, have_last;
  logic [ROW_BITS-1:0] last_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_prev  <= 1'b1;
      armed     <= 1'b0;
      have_last <= 1'b0;
      last_row  <= '0;
    end else begin
      row_prev <= row_n;
      armed    <= 1'b1;
      if (refresh_pulse) begin
        have_last <= 1'b1;
        last_row  <= refresh_row;
      end
    end
  end

  // R1: idle fall with refresh strobe low produces a pulse
  assert_fall_refresh_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (row_prev && !row_n && !rfsh_n && !self_active && !recovery_busy) |=> refresh_pulse);

  // R2: consecutive refreshed rows step by one
  assert_row_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_pulse && have_last) |-> (refresh_row == ROW_BITS'(last_row + 1'b1)));

  // R5: high row strobe in self-refresh ends the mode
  assert_self_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (self_active && row_n) |=> (!self_active && recovery_busy && !refresh_pulse));

  // R6: modes are exclusive
  assert_mode_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({self_active, recovery_busy}));

  // R7: a flagged access never refreshes
  assert_err_no_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !refresh_pulse);

  // R8: standby flag follows chip select
  assert_standby_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    low_power == $past(sel_n));
endmodule

bind refresh_ctrl refresh_ctrl_chk #(.ROW_BITS(ROW_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rfsh_n(rfsh_n), .row_n(row_n),
  .refresh_pulse(refresh_pulse), .refresh_row(refresh_row),
  .self_active(self_active), .recovery_busy(recovery_busy),
  .proto_err(proto_err), .low_power(low_power)
);

// File: tb/refresh_ctrl_tb.sv
module refresh_ctrl_tb;
  localparam int RB  = 10;
  localparam int SP  = 7;
  localparam int RC  = 5;
  localparam int WIN = 300;
  localparam int REQ = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b0, wr_sel = 1'b0, rfsh_n = 1'b1, row_n = 1'b1, col_n = 1'b1, we_n = 1'b1;
  logic refresh_pulse, self_active, recovery_busy, proto_err, low_power, budget_warn;
  logic [RB-1:0] refresh_row;

  int checks = 0;
  int fails = 0;
  logic [RB-1:0] exp_row = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  refresh_ctrl #(.ROW_BITS(RB), .SELF_PERIOD(SP), .RECOVER_CYC(RC),
                 .WINDOW_CYC(WIN), .REQ_REFRESH(REQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_sel(wr_sel), .rfsh_n(rfsh_n),
    .row_n(row_n), .col_n(col_n), .we_n(we_n), .refresh_pulse(refresh_pulse),
    .refresh_row(refresh_row), .self_active(self_active),
    .recovery_busy(recovery_busy), .proto_err(proto_err),
    .low_power(low_power), .budget_warn(budget_warn)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_self_combo(input logic s, input logic w, input logic f,
                                       input logic e, input logic c);
    return s && w && f && e && !c;
  endfunction

  task automatic idle_pins();
    sel_n = 1'b0; wr_sel = 1'b0; rfsh_n = 1'b1; row_n = 1'b1; col_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic do_reset();
    idle_pins();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_row = '0;
  endtask

  // R1 R2: one internal refresh
  task automatic int_refresh();
    rfsh_n = 1'b0; row_n = 1'b0;
    @(negedge clk);
    chk("R1 pulse", int'(refresh_pulse), 1);
    chk("R2 row", int'(refresh_row), int'(exp_row));
    exp_row = exp_row + 1'b1;
    rfsh_n = 1'b1; row_n = 1'b1;
    @(negedge clk);
    chk("R1 single", int'(refresh_pulse), 0);
  endtask

  // R10 R8: ordinary access fall
  task automatic plain_access();
    logic s, w, e, c;
    s = 1'($urandom); w = 1'($urandom); e = 1'($urandom); c = 1'($urandom);
    if (is_self_combo(s, w, 1'b1, e, c)) c = 1'b1;
    sel_n = s; wr_sel = w; we_n = e; col_n = c; rfsh_n = 1'b1; row_n = 1'b0;
    @(negedge clk);
    chk("R10 no pulse", int'(refresh_pulse), 0);
    chk("R10 no mode", int'(self_active), 0);
    chk("R8 standby", int'(low_power), int'(s));
    idle_pins();
    @(negedge clk);
  endtask

  // R3 R4 R5 R6 R7: one self-refresh stay of d clocks
  task automatic self_episode(input int d, input bit with_err);
    int seen;
    seen = 0;
    sel_n = 1'b1; wr_sel = 1'b1; rfsh_n = 1'b1; we_n = 1'b1; col_n = 1'b0; row_n = 1'b0;
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      chk("R3 self_active", int'(self_active), 1);
      if (refresh_pulse) begin
        seen++;
        chk("R2 self row", int'(refresh_row), int'(exp_row));
        exp_row = exp_row + 1'b1;
      end
      col_n = 1'b1;
    end
    chk("R4 self pulses", seen, (d - 1) / SP);
    row_n = 1'b1;
    for (int i = 0; i < RC; i++) begin
      @(negedge clk);
      chk("R5 exited", int'(self_active), 0);
      chk("R6 busy", int'(recovery_busy), 1);
      if (i == 0) chk("R5 no pulse", int'(refresh_pulse), 0);
      if (with_err && i == 0) begin
        rfsh_n = 1'b0; row_n = 1'b0;
      end
      if (with_err && i == 1) begin
        chk("R7 err", int'(proto_err), 1);
        chk("R7 no pulse", int'(refresh_pulse), 0);
        rfsh_n = 1'b1; row_n = 1'b1;
      end
      if (with_err && i == 2) chk("R7 err one clock", int'(proto_err), 0);
    end
    @(negedge clk);
    chk("R6 busy end", int'(recovery_busy), 0);
    idle_pins();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    @(negedge clk);
    chk("R2 reset pulse", int'(refresh_pulse), 0);
    chk("R3 reset mode", int'(self_active), 0);
    chk("R6 reset busy", int'(recovery_busy), 0);
    chk("R9 reset warn", int'(budget_warn), 0);
    chk("R7 reset err", int'(proto_err), 0);

    // R9: enough refreshes in the first window, none in the second
    for (int i = 0; i < REQ + 2; i++) int_refresh();
    repeat (WIN + 10) @(negedge clk);
    chk("R9 met", int'(budget_warn), 0);
    repeat (WIN) @(negedge clk);
    chk("R9 missed", int'(budget_warn), 1);

    // R4 corners: stay shorter than a period, exactly one period plus one
    self_episode(1, 1'b0);
    self_episode(SP, 1'b0);
    self_episode(SP + 1, 1'b1);
    int_refresh();  // R7: counter unchanged by the flagged access

    // R2 wrap
    do_reset();
    for (int i = 0; i < (1 << RB) + 4; i++) int_refresh();

    // random mix
    for (int n = 0; n < 300; n++) begin
      case ($urandom % 4)
        0, 1: int_refresh();
        2: plain_access();
        default: self_episode(1 + int'($urandom % 40), 1'($urandom));
      endcase
    end
    int_refresh();

    done = 1'b1;
    finish_run();
  end
endmodule